// File: doc/BRIEF.md
# NAND Program and Erase Sequencer

This block sits on the host side of a raw 8-bit NAND flash bus. It carries out two kinds of request: writing a page and erasing a block. A request gives the operation, a column byte and a 24-bit row address, and selects how completion is detected. For a page write, the user then streams the payload bytes over a valid/ready channel. The stream may be shorter than the page. It ends on the byte flagged last, or when the configured maximum is reached.

The sequencer drives the command-latch, address-latch, write-strobe and read-strobe lines and the 8-bit output bus in the order the flash expects. After the confirm command it waits for the operation to finish. Completion is detected in one of two ways:
- Ready/busy mode: the sequencer waits for the ready/busy input, then issues one status read.
- Polling mode: the sequencer issues the status command and re-reads status until the ready bit is set.

It then reports pass or fail with a single-cycle done pulse. A timeout ends a wait that never completes.

Every strobe holds low for a set number of clocks. The bus is set up one phase before the falling edge and held one phase after the rising edge.

Top module: `nand_prog_seq`

## Requirements
- R1: A page write emits, in order: command 80h, four address bytes (column byte, then row bits 7:0, 15:8, 23:16), the accepted payload bytes in arrival order, then command 10h.
- R2: A block erase emits, in order: command 60h, three address bytes (row bits 7:0, 15:8, 23:16), then command D0h.
- R3: Payload bytes are taken only when `wr_valid` and `wr_ready` are both high. The stream ends after the byte carrying `wr_last`, or after DATA_MAX bytes, whichever comes first. After that, `wr_ready` stays low for the rest of the operation.
- R4: Each write strobe holds `nf_we_n` low for exactly WE_LOW clocks. The bus, `nf_cle` and `nf_ale` are unchanged from the falling edge through the rising edge. Command bytes carry `nf_cle` only, address bytes carry `nf_ale` only, and payload bytes carry neither.
- R5: In ready/busy mode (`req_poll`=0), the status command 70h is issued only once `nf_rb` is high. Exactly one status read follows it, and `fail` equals bit 0 of that status byte.
- R6: In polling mode (`req_poll`=1), 70h is issued after the confirm command, and status is re-read until bit 6 is 1. `fail` equals bit 0 of the status byte that had bit 6 set.
- R7: Between the confirm command and `done`, the only command latched is 70h.
- R8: If completion is not seen within TIMEOUT clocks of the wait starting, the operation ends with `done`, `fail`=1 and `timeout`=1.
- R9: `req_ready` is high only while idle. A request raised during an operation is ignored and does not change the byte sequence. Each operation yields exactly one single-cycle `done` pulse.
- R10: After reset the block is idle. `req_ready` is 1, `nf_we_n` and `nf_re_n` are 1, and `nf_cle`, `nf_ale`, `nf_io_oe`, `wr_ready` and `done` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request strobe, taken while idle |
| req_ready | output | 1 | High while idle |
| req_erase | input | 1 | 1 = block erase, 0 = page write |
| req_poll | input | 1 | 1 = detect completion by polling status, 0 = by ready/busy |
| req_col | input | 8 | Column byte (page write only) |
| req_row | input | 24 | Row address, sent low byte first |
| wr_valid | input | 1 | Payload byte valid |
| wr_ready | output | 1 | Payload byte can be taken |
| wr_data | input | 8 | Payload byte |
| wr_last | input | 1 | Marks the final payload byte |
| nf_cle | output | 1 | Command latch enable |
| nf_ale | output | 1 | Address latch enable |
| nf_we_n | output | 1 | Write strobe, active low |
| nf_re_n | output | 1 | Read strobe, active low |
| nf_io_out | output | 8 | Bus value driven by the sequencer |
| nf_io_oe | output | 1 | Bus drive enable |
| nf_io_in | input | 8 | Bus value read from the flash |
| nf_rb | input | 1 | Ready/busy, 1 = ready |
| done | output | 1 | One-cycle end-of-operation pulse |
| fail | output | 1 | Valid with done: operation failed |
| timeout | output | 1 | Valid with done: completion never seen |

## Verification
The bench sweeps every payload length from one byte to the maximum, under both completion modes and with both status outcomes. This catches a design that miscounts address cycles or drops the final payload byte, because such a design would shift the whole latched sequence. A stream offered without a last flag and longer than the maximum must stop at the cap. A design that ignored the cap would swallow extra bytes and never confirm.

The other corner cases each target a specific wrong design:
- A slow ready/busy: a design that issued 70h early would latch it while the flash is busy.
- A flash that never becomes ready, in each mode: a design without a working timeout would hang.
- A request raised mid-operation: a design that accepted it would switch to the erase opcodes or restart the sequence.

// File: rtl/nand_prog_seq.sv
module nand_prog_seq #(
  parameter int DATA_MAX = 528,
  parameter int SETUP    = 1,
  parameter int WE_LOW   = 2,
  parameter int HOLD     = 1,
  parameter int GUARD    = 4,
  parameter int TIMEOUT  = 100000
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        req_valid,
  output logic        req_ready,
  input  logic        req_erase,
  input  logic        req_poll,
  input  logic [7:0]  req_col,
  input  logic [23:0] req_row,
  input  logic        wr_valid,
  output logic        wr_ready,
  input  logic [7:0]  wr_data,
  input  logic        wr_last,
  output logic        nf_cle,
  output logic        nf_ale,
  output logic        nf_we_n,
  output logic        nf_re_n,
  output logic [7:0]  nf_io_out,
  output logic        nf_io_oe,
  input  logic [7:0]  nf_io_in,
  input  logic        nf_rb,
  output logic        done,
  output logic        fail,
  output logic        timeout
);
  localparam int T  = SETUP + WE_LOW + HOLD;
  localparam int PW = $clog2(T + 1);
  localparam int CW = $clog2(DATA_MAX + 1);
  localparam int TW = $clog2(TIMEOUT + 1);
  localparam logic [PW-1:0] PH_LO  = PW'(SETUP);
  localparam logic [PW-1:0] PH_HI  = PW'(SETUP + WE_LOW);
  localparam logic [PW-1:0] PH_SMP = PW'(SETUP + WE_LOW - 1);
  localparam logic [PW-1:0] PH_END = PW'(T - 1);

  typedef enum logic [2:0] {S_IDLE, S_CMD1, S_ADDR, S_DATA, S_CMD2, S_WAIT, S_STCMD, S_STREAD} st_t;

  st_t           st;
  logic          act;
  logic [PW-1:0] ph;
  logic [7:0]    bus, stat, col, abyte;
  logic [23:0]   row;
  logic          op_erase, op_poll, last_in;
  logic [1:0]    ai;
  logic [CW-1:0] cnt;
  logic [TW-1:0] tcnt;
  logic          writing, strobe, cyc_end;

  assign writing   = st inside {S_CMD1, S_ADDR, S_DATA, S_CMD2, S_STCMD};
  assign strobe    = act && ph >= PH_LO && ph < PH_HI;
  assign cyc_end   = act && ph == PH_END;
  assign nf_we_n   = !(strobe && writing);
  assign nf_re_n   = !(strobe && st == S_STREAD);
  assign nf_cle    = act && st inside {S_CMD1, S_CMD2, S_STCMD};
  assign nf_ale    = act && st == S_ADDR;
  assign nf_io_oe  = act && writing;
  assign nf_io_out = bus;
  assign req_ready = st == S_IDLE;
  assign wr_ready  = st == S_DATA && !act;

  always_comb begin
    case (op_erase ? ai + 2'd1 : ai)
      2'd0:    abyte = col;
      2'd1:    abyte = row[7:0];
      2'd2:    abyte = row[15:8];
      default: abyte = row[23:16];
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE; act <= 1'b0; ph <= '0; bus <= '0; stat <= '0;
      col <= '0; row <= '0; op_erase <= 1'b0; op_poll <= 1'b0; last_in <= 1'b0;
      ai <= '0; cnt <= '0; tcnt <= '0; done <= 1'b0; fail <= 1'b0; timeout <= 1'b0;
    end else begin
      done <= 1'b0;
      if (act) ph <= ph + 1'b1;
      if (cyc_end) begin act <= 1'b0; ph <= '0; end
      if (st inside {S_WAIT, S_STCMD, S_STREAD} && tcnt != TW'(TIMEOUT)) tcnt <= tcnt + 1'b1;
      case (st)
        S_IDLE: if (req_valid) begin
          op_erase <= req_erase; op_poll <= req_poll; col <= req_col; row <= req_row;
          st <= S_CMD1;
        end
        S_CMD1: if (!act) begin
          bus <= op_erase ? 8'h60 : 8'h80; act <= 1'b1;
        end else if (cyc_end) begin
          st <= S_ADDR; ai <= '0;
        end
        S_ADDR: if (!act) begin
          bus <= abyte; act <= 1'b1;
        end else if (cyc_end) begin
          if (ai == (op_erase ? 2'd2 : 2'd3)) begin
            st <= op_erase ? S_CMD2 : S_DATA; cnt <= '0;
          end else ai <= ai + 2'd1;
        end
        S_DATA: if (!act) begin
          if (wr_valid) begin
            bus <= wr_data; act <= 1'b1; cnt <= cnt + 1'b1;
            last_in <= wr_last || cnt == CW'(DATA_MAX - 1);
          end
        end else if (cyc_end && last_in) st <= S_CMD2;
        S_CMD2: if (!act) begin
          bus <= op_erase ? 8'hD0 : 8'h10; act <= 1'b1;
        end else if (cyc_end) begin
          st <= S_WAIT; tcnt <= '0;
        end
        S_WAIT: if (tcnt >= TW'(GUARD) && (op_poll || nf_rb)) st <= S_STCMD;
          else if (tcnt == TW'(TIMEOUT)) begin
            done <= 1'b1; fail <= 1'b1; timeout <= 1'b1; st <= S_IDLE;
          end
        S_STCMD: if (!act) begin
          bus <= 8'h70; act <= 1'b1;
        end else if (cyc_end) st <= S_STREAD;
        S_STREAD: if (!act) act <= 1'b1;
          else begin
            if (ph == PH_SMP) stat <= nf_io_in;
            if (cyc_end) begin
              if (!op_poll || stat[6]) begin
                done <= 1'b1; fail <= stat[0]; timeout <= 1'b0; st <= S_IDLE;
              end else if (tcnt == TW'(TIMEOUT)) begin
                done <= 1'b1; fail <= 1'b1; timeout <= 1'b1; st <= S_IDLE;
              end
            end
          end
        default: st <= S_IDLE;
      endcase
    end
  end

  assert_we_rise_stable_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(nf_we_n) |-> $stable(nf_io_out) && $stable(nf_cle) && $stable(nf_ale));
  assert_latch_exclusive_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !nf_we_n |-> nf_io_oe && !(nf_cle && nf_ale) && nf_re_n);
  assert_busy_cmd_only_status_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (st inside {S_WAIT, S_STCMD, S_STREAD} && nf_cle && !nf_we_n) |-> nf_io_out == 8'h70);
  assert_take_only_undriven_R3: assert property (@(posedge clk) disable iff (!rst_n)
    wr_ready |-> !nf_io_oe && nf_we_n);
  assert_done_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  assert_timeout_fails_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (done && timeout) |-> fail);
endmodule

// File: tb/sim_nand_prog_seq.sv
`timescale 1ns/1ps
module sim_nand_prog_seq;
  localparam int DMAX = 8, SETUP = 1, WE_LOW = 2, HOLD = 1, GUARD = 3, TMO = 60;
  localparam int BIG = 1000000;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 1'b0, req_erase = 1'b0, req_poll = 1'b0;
  logic [7:0] req_col = '0;
  logic [23:0] req_row = '0;
  logic wr_valid = 1'b0, wr_last = 1'b0;
  logic [7:0] wr_data = '0;
  logic req_ready, wr_ready, nf_cle, nf_ale, nf_we_n, nf_re_n, nf_io_oe, done, fail, timeout;
  logic [7:0] nf_io_out, nf_io_in;
  logic nf_rb;

  int total = 0, fails = 0;
  int model_busy = 0, op_id = 0, seen_id = 0;
  bit model_fail = 1'b0;
  int busy_left = 0, nlog = 0, serr = 0, berr = 0, nreads = 0, wl = 0;
  bit busy70 = 1'b0, pwe = 1'b1, pre = 1'b1, fcle, fale;
  logic [7:0] fio;
  int lg_kind [0:63];
  int lg_val  [0:63];

  always #2.5 clk = ~clk;

  assign nf_rb    = (busy_left == 0);
  assign nf_io_in = {1'b0, busy_left == 0, 5'b0, model_fail};

  nand_prog_seq #(.DATA_MAX(DMAX), .SETUP(SETUP), .WE_LOW(WE_LOW), .HOLD(HOLD),
                  .GUARD(GUARD), .TIMEOUT(TMO)) u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_erase(req_erase), .req_poll(req_poll), .req_col(req_col), .req_row(req_row),
    .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_data(wr_data), .wr_last(wr_last),
    .nf_cle(nf_cle), .nf_ale(nf_ale), .nf_we_n(nf_we_n), .nf_re_n(nf_re_n),
    .nf_io_out(nf_io_out), .nf_io_oe(nf_io_oe), .nf_io_in(nf_io_in), .nf_rb(nf_rb),
    .done(done), .fail(fail), .timeout(timeout));

  // flash model and bus monitor, sampled on the falling clock edge
  always @(negedge clk) begin
    if (op_id != seen_id) begin
      seen_id = op_id; nlog = 0; serr = 0; berr = 0; nreads = 0; busy70 = 1'b0; busy_left = 0;
    end
    if (busy_left > 0 && busy_left < BIG) busy_left--;
    if (!nf_we_n) begin
      if (pwe) begin fio = nf_io_out; fcle = nf_cle; fale = nf_ale; wl = 1; end
      else wl++;
    end else if (!pwe) begin
      if (wl != WE_LOW || nf_io_out != fio || nf_cle != fcle || nf_ale != fale || (nf_cle && nf_ale))
        serr++;
      if (nlog < 64) begin
        lg_kind[nlog] = nf_cle ? 0 : (nf_ale ? 1 : 2);
        lg_val[nlog]  = int'(nf_io_out);
        nlog++;
      end
      if (nf_cle && busy_left > 0 && nf_io_out != 8'h70) berr++;
      if (nf_cle && nf_io_out == 8'h70) busy70 = (busy_left > 0);
      if (nf_cle && (nf_io_out == 8'h10 || nf_io_out == 8'hD0)) busy_left = model_busy;
    end
    if (nf_re_n && !pre) nreads++;
    pwe = nf_we_n; pre = nf_re_n;
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d (op %0d)", tag, act, exp, op_id);
    end
  endtask

  function automatic logic [7:0] dat(input int i, input int id);
    return 8'(i * 29 + id * 7 + 3);
  endfunction

  task automatic run_op(input bit er, input bit pl, input int len, input bit use_last,
                        input int busy, input bit fb, input bit intrude);
    int i = 0, extra = 0, m = 0, mism = 0, expn;
    bit pend = 1'b0, got = 1'b0, gf = 1'b0, gt = 1'b0, tmo;
    logic [7:0] c;
    logic [23:0] r;
    int ek [0:63];
    int ev [0:63];
    model_busy = busy; model_fail = fb; op_id++;
    c = 8'(op_id * 13 + 5); r = 24'(op_id * 40503 + 7);
    @(negedge clk);
    req_erase = er; req_poll = pl; req_col = c; req_row = r; req_valid = 1'b1;
    chk(req_ready == 1'b1, "R9 idle ready", int'(req_ready), 1);
    @(negedge clk);
    req_valid = 1'b0;
    for (int k = 0; k < 4000 && !got; k++) begin
      if (pend) begin i++; pend = 1'b0; end
      if (done) begin got = 1'b1; gf = fail; gt = timeout; end
      else begin
        wr_valid = (i < len);
        wr_data  = dat(i, op_id);
        wr_last  = use_last && (i == len - 1);
        if (wr_valid && wr_ready) pend = 1'b1;
        if (intrude && k == 6) begin
          chk(req_ready == 1'b0, "R9 busy not ready", int'(req_ready), 0);
          req_valid = 1'b1; req_erase = !er; req_col = 8'hEE;
        end else req_valid = 1'b0;
        @(negedge clk);
      end
    end
    wr_valid = 1'b0; wr_last = 1'b0; req_valid = 1'b0;
    for (int k = 0; k < 8; k++) begin
      @(negedge clk);
      if (done) extra++;
    end
    tmo = (busy >= BIG);
    expn = use_last ? len : (len < DMAX ? len : DMAX);
    chk(got, "R9 done seen", int'(got), 1);
    chk(extra == 0, "R9 single done", extra, 0);
    if (!er) chk(i == expn, "R3 bytes taken", i, expn);
    ek[m] = 0; ev[m] = er ? 32'h60 : 32'h80; m++;
    if (!er) begin ek[m] = 1; ev[m] = int'(c); m++; end
    for (int b = 0; b < 3; b++) begin ek[m] = 1; ev[m] = int'(r[8*b +: 8]); m++; end
    if (!er) for (int b = 0; b < expn; b++) begin ek[m] = 2; ev[m] = int'(dat(b, op_id)); m++; end
    ek[m] = 0; ev[m] = er ? 32'hD0 : 32'h10; m++;
    if (!(tmo && !pl)) begin ek[m] = 0; ev[m] = 32'h70; m++; end
    if (nlog != m) mism = 1;
    else for (int b = 0; b < m; b++) if (lg_kind[b] != ek[b] || lg_val[b] != ev[b]) mism++;
    if (er) chk(mism == 0, "R2 erase sequence", nlog, m);
    else    chk(mism == 0, "R1 write sequence", nlog, m);
    chk(serr == 0, "R4 strobe shape", serr, 0);
    chk(berr == 0, "R7 busy commands", berr, 0);
    chk(gt == tmo, "R8 timeout flag", int'(gt), int'(tmo));
    if (tmo) chk(gf == 1'b1, "R8 timeout fail", int'(gf), 1);
    else if (pl) begin
      chk(gf == fb, "R6 poll fail flag", int'(gf), int'(fb));
      if (busy >= 40) chk(nreads >= 2, "R6 repeated polls", nreads, 2);
    end else begin
      chk(gf == fb, "R5 rb fail flag", int'(gf), int'(fb));
      chk(nreads == 1, "R5 single status read", nreads, 1);
      chk(busy70 == 1'b0, "R5 status after ready", int'(busy70), 0);
    end
  endtask

  initial begin
    #(5.0 * 150000);
    fails++; total++;
    $display("FAIL R9 watchdog actual=hung expected=finished");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R10: idle outputs while and after reset
    chk(req_ready == 1'b1 && nf_we_n && nf_re_n, "R10 reset strobes", int'({req_ready, nf_we_n, nf_re_n}), 7);
    chk(!nf_cle && !nf_ale && !nf_io_oe, "R10 reset latches", int'({nf_cle, nf_ale, nf_io_oe}), 0);
    chk(!wr_ready && !done, "R10 reset handshake", int'({wr_ready, done}), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(req_ready == 1'b1 && nf_we_n && !done, "R10 after release", int'({req_ready, nf_we_n, done}), 6);
    for (int p = 0; p < 2; p++)
      for (int len = 1; len <= DMAX; len++)
        run_op(1'b0, p[0], len, 1'b1, (len % 3) * 20, len[0], 1'b0);
    run_op(1'b0, 1'b0, DMAX + 3, 1'b0, 10, 1'b0, 1'b0);
    run_op(1'b0, 1'b1, DMAX + 3, 1'b0, 45, 1'b1, 1'b0);
    run_op(1'b1, 1'b0, 0, 1'b0, 30, 1'b0, 1'b0);
    run_op(1'b1, 1'b0, 0, 1'b0, 0, 1'b1, 1'b0);
    run_op(1'b1, 1'b1, 0, 1'b0, 50, 1'b0, 1'b0);
    run_op(1'b1, 1'b1, 0, 1'b0, 5, 1'b1, 1'b0);
    run_op(1'b0, 1'b0, 3, 1'b1, BIG, 1'b0, 1'b0);
    run_op(1'b1, 1'b1, 0, 1'b0, BIG, 1'b0, 1'b0);
    run_op(1'b0, 1'b1, 4, 1'b1, 25, 1'b0, 1'b1);
    run_op(1'b1, 1'b0, 0, 1'b0, 25, 1'b1, 1'b1);
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule